// File: doc/BRIEF.md
# Driver Strength Calibration Controller

This block keeps the drive strength of an output pad constant as process, supply voltage and temperature drift. A free-running ring oscillator, built from an odd number of inverters, runs faster on a fast corner and slower on a slow one. The controller counts its rising edges over a programmable window of system-clock cycles and compares the count with a programmed target.

A slow reading switches on one more parallel leg in both the pull-up and the pull-down stacks of the driver. A fast reading switches one leg off in each stack. A reading inside a fixed deadband around the target leaves both stacks as they are. After two in-band readings in a row the block raises a done flag, and later firmware or sequencing logic can use the leg codes. The leg codes go straight to the analog driver as thermometer-coded enable words.

Top module: `drv_cal_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, `pu_en` and `pd_en` both read 8'h0F (four legs on) and `done` is 0.
- R2: While `en` is high, windows of exactly `win_len` system-clock cycles follow each other with no gap. Each window counts the rising edges of the synchronized `osc_in` seen during its cycles.
- R3: If a window's count plus the deadband BAND (1 by default) is below `target`, each leg code gains one enabled leg. A code that is already all ones stays as it is.
- R4: If a window's count is above `target` plus BAND, each leg code loses one enabled leg. A code that is already zero stays as it is.
- R5: Leg codes are thermometer coded: with n legs on, bits [n-1:0] are 1 and all higher bits are 0. The codes saturate at 8'hFF and 8'h00 and never wrap around.
- R6: A leg code changes only on the clock edge right after a window closes, and by at most one leg per window.
- R7: `done` rises on the clock edge after the second window in a row whose count lies inside target±BAND. It falls on the clock edge after any later window that lies outside that band.
- R8: While `en` is low, the window timer and edge count are held cleared, and `pu_en`, `pd_en` and `done` keep their values.
- R9: `pu_en` and `pd_en` always enable the same number of legs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| en | input | 1 | Calibration enable |
| osc_in | input | 1 | Ring-oscillator output, asynchronous to clk |
| win_len | input | 16 | Window length in system-clock cycles |
| target | input | 16 | Expected edge count per window |
| pu_en | output | 8 | Pull-up leg enables, thermometer code |
| pd_en | output | 8 | Pull-down leg enables, thermometer code |
| done | output | 1 | Two consecutive in-band windows seen |

## Verification
The assertions assume that `win_len` is nonzero and does not change while `en` is high. They also assume that no window holds more edges than the count width can represent, and that `osc_in` stays high and low for at least one system-clock cycle each. The stimulus keeps to these limits. It changes `win_len`, `target` and the oscillator period only under reset or with `en` low. It drives the oscillator as a square wave whose period is a whole number of clock cycles of at least two, with the window length a multiple of that period. This makes each window's count exactly the window length divided by the period, so the bench can compute it.

// File: rtl/drv_cal_pkg.sv
package drv_cal_pkg;
  typedef enum logic [1:0] {
    V_HOLD = 2'd0,
    V_UP   = 2'd1,
    V_DOWN = 2'd2,
    V_NONE = 2'd3
  } verdict_e;
endpackage

// File: rtl/osc_sync_edge.sv
module osc_sync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_in,
  output logic rise
);
  logic meta_q, sync_q, last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      meta_q <= osc_in;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  always_comb rise = sync_q & ~last_q;
endmodule

// File: rtl/win_counter.sv
module win_counter #(
  parameter int WIN_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             rise,
  input  logic [WIN_W-1:0] win_len,
  output logic [CNT_W-1:0] meas,
  output logic             meas_vld
);
  logic [WIN_W-1:0] timer_q, timer_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, meas_q, meas_d, sum;
  logic             vld_d, vld_q, last;

  always_comb begin
    last    = (timer_q == win_len - 1'b1);
    sum     = cnt_q + {{(CNT_W-1){1'b0}}, rise};
    timer_d = timer_q + 1'b1;
    cnt_d   = sum;
    meas_d  = meas_q;
    vld_d   = 1'b0;
    if (!en) begin
      timer_d = '0;
      cnt_d   = '0;
    end else if (last) begin
      timer_d = '0;
      cnt_d   = '0;
      meas_d  = sum;
      vld_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timer_q <= '0;
      cnt_q   <= '0;
      meas_q  <= '0;
      vld_q   <= 1'b0;
    end else begin
      timer_q <= timer_d;
      cnt_q   <= cnt_d;
      meas_q  <= meas_d;
      vld_q   <= vld_d;
    end
  end

  always_comb begin
    meas     = meas_q;
    meas_vld = vld_q;
  end
endmodule

// File: rtl/leg_stepper.sv
module leg_stepper
  import drv_cal_pkg::*;
#(
  parameter int LEGS       = 8,
  parameter int RESET_LEGS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  verdict_e        verdict,
  output logic [LEGS-1:0] code
);
  localparam logic [LEGS-1:0] INIT = {LEGS{1'b1}} >> (LEGS - RESET_LEGS);

  logic [LEGS-1:0] code_q, code_d;
  logic            step_en;

  always_comb begin
    step_en = (verdict == V_UP) || (verdict == V_DOWN);
    code_d  = code_q;
    if (verdict == V_UP)   code_d = {code_q[LEGS-2:0], 1'b1};
    if (verdict == V_DOWN) code_d = {1'b0, code_q[LEGS-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= INIT;
    else if (step_en) code_q <= code_d;
  end

  always_comb code = code_q;
endmodule

// File: rtl/drv_cal_ctrl.sv
module drv_cal_ctrl
  import drv_cal_pkg::*;
#(
  parameter int LEGS       = 8,
  parameter int RESET_LEGS = 4,
  parameter int WIN_W      = 16,
  parameter int CNT_W      = 16,
  parameter int BAND       = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             osc_in,
  input  logic [WIN_W-1:0] win_len,
  input  logic [CNT_W-1:0] target,
  output logic [LEGS-1:0]  pu_en,
  output logic [LEGS-1:0]  pd_en,
  output logic             done
);
  localparam logic [CNT_W:0] BAND_X = (CNT_W+1)'(BAND);

  logic             rise, meas_vld;
  logic [CNT_W-1:0] meas;
  logic [CNT_W:0]   meas_x, tgt_x;
  verdict_e         verdict;
  logic [1:0]       streak_q, streak_d;
  logic [LEGS-1:0]  codes [2];

  osc_sync_edge u_sync (.clk(clk), .rst_n(rst_n), .osc_in(osc_in), .rise(rise));

  win_counter #(.WIN_W(WIN_W), .CNT_W(CNT_W)) u_win (
    .clk(clk), .rst_n(rst_n), .en(en), .rise(rise), .win_len(win_len),
    .meas(meas), .meas_vld(meas_vld)
  );

  always_comb begin
    meas_x  = {1'b0, meas};
    tgt_x   = {1'b0, target};
    verdict = V_NONE;
    if (meas_vld && en) begin
      if (meas_x + BAND_X < tgt_x)      verdict = V_UP;
      else if (meas_x > tgt_x + BAND_X) verdict = V_DOWN;
      else                              verdict = V_HOLD;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_stack
    leg_stepper #(.LEGS(LEGS), .RESET_LEGS(RESET_LEGS)) u_step (
      .clk(clk), .rst_n(rst_n), .verdict(verdict), .code(codes[g])
    );
  end

  always_comb begin
    streak_d = streak_q;
    case (verdict)
      V_HOLD:  streak_d = streak_q[1] ? 2'd2 : streak_q + 2'd1;
      V_UP,
      V_DOWN:  streak_d = 2'd0;
      default: streak_d = streak_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) streak_q <= 2'd0;
    else        streak_q <= streak_d;
  end

  always_comb begin
    pu_en = codes[0];
    pd_en = codes[1];
    done  = streak_q[1];
  end
endmodule

// File: rtl/drv_cal_chk.sv
module drv_cal_chk #(
  parameter int LEGS  = 8,
  parameter int CNT_W = 16,
  parameter int BAND  = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic [CNT_W-1:0] target,
  input logic [CNT_W-1:0] meas,
  input logic             meas_vld,
  input logic [LEGS-1:0]  pu_en,
  input logic [LEGS-1:0]  pd_en,
  input logic             done
);
  localparam logic [CNT_W:0] BX = (CNT_W+1)'(BAND);
  logic slow, fast;
  always_comb begin
    slow = ({1'b0, meas} + BX) < {1'b0, target};
    fast = {1'b0, meas} > ({1'b0, target} + BX);
  end

  p_legs_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pu_en == pd_en);
  p_thermo_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pu_en & (pu_en + 1'b1)) == '0);
  p_one_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pu_en ^ $past(pu_en)) <= 1);
  p_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pu_en != $past(pu_en)) |-> $past(meas_vld));
  p_slow_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && meas_vld && slow && !(&pu_en)) |=>
      ($countones(pu_en) == $countones($past(pu_en)) + 1));
  p_fast_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && meas_vld && fast && (|pu_en)) |=>
      ($countones(pu_en) + 1 == $countones($past(pu_en))));
  p_done_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && meas_vld && (slow || fast)) |=> !done);
  p_en_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(pu_en) && $stable(done)));
endmodule

bind drv_cal_ctrl drv_cal_chk #(.LEGS(LEGS), .CNT_W(CNT_W), .BAND(BAND)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .target(target), .meas(meas),
  .meas_vld(meas_vld), .pu_en(pu_en), .pd_en(pd_en), .done(done)
);

// File: tb/drv_cal_ctrl_test.sv
module drv_cal_ctrl_test;
  localparam int LEGS = 8;
  localparam int B    = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        osc = 1'b0;
  logic [15:0] win_len = 16'd24;
  logic [15:0] target = 16'd0;
  logic [7:0]  pu_en, pd_en;
  logic        done;

  int per = 4;
  int ph = 0;
  int n_chk = 0;
  int n_bad = 0;

  drv_cal_ctrl uut (
    .clk(clk), .rst_n(rst_n), .en(en), .osc_in(osc), .win_len(win_len),
    .target(target), .pu_en(pu_en), .pd_en(pd_en), .done(done)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    ph  <= (ph + 1 >= per) ? 0 : ph + 1;
    osc <= (ph < per / 2);
  end

  function automatic logic [7:0] therm(input int n);
    logic [8:0] t;
    t = (9'd1 << n) - 9'd1;
    return t[7:0];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    en    = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3 * per + 4) @(posedge clk);
    @(negedge clk);
  endtask

  // Runs one case from reset; count per window is w/p.
  task automatic run_case(input int w, input int p, input int t);
    int c, dir, lvl;
    per = p; win_len = 16'(w); target = 16'(t);
    do_reset();
    check(pu_en == 8'h0F && pd_en == 8'h0F && !done, "R1 reset", pu_en, 8'h0F);
    c   = w / p;
    dir = (c + B < t) ? 1 : (c > t + B) ? -1 : 0;
    lvl = 4;
    en  = 1'b1;
    repeat (w / 2 + 1) @(posedge clk);
    for (int k = 1; k <= 6; k++) begin
      repeat (w) @(posedge clk);
      @(negedge clk);
      lvl = lvl + dir;
      if (lvl > LEGS) lvl = LEGS;
      if (lvl < 0) lvl = 0;
      check(pu_en == therm(lvl), dir > 0 ? "R3/R5 slow step" :
            dir < 0 ? "R4/R5 fast step" : "R2 in band hold", pu_en, therm(lvl));
      check(pd_en == pu_en, "R9 stacks match", pd_en, pu_en);
      check(done == (dir == 0 && k >= 2), "R7 done", done, (dir == 0 && k >= 2));
    end
  endtask

  initial begin
    #(10 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    // Near-exhaustive sweep: two windows, six periods, sixteen targets
    foreach (win_len[i]) begin end
    for (int wi = 0; wi < 2; wi++) begin
      for (int pi = 0; pi < 6; pi++) begin
        for (int t = 0; t < 16; t++) begin
          int pp;
          case (pi)
            0: pp = 2; 1: pp = 3; 2: pp = 4;
            3: pp = 6; 4: pp = 8; default: pp = 12;
          endcase
          run_case(wi == 0 ? 24 : 48, pp, t);
        end
      end
    end

    // R7: done clears when a later window leaves the band; R6 one step per window
    run_case(24, 4, 6);
    check(done == 1'b1, "R7 locked before drift", done, 1);
    en  = 1'b0;
    per = 2;
    repeat (40) @(posedge clk);
    @(negedge clk);
    check(pu_en == 8'h0F && done == 1'b1, "R8 hold while disabled", pu_en, 8'h0F);
    en = 1'b1;
    repeat (24 / 2 + 1 + 24) @(posedge clk);
    @(negedge clk);
    check(done == 1'b0, "R7 done cleared", done, 0);
    check(pu_en == 8'h07, "R6 single step after one window", pu_en, 8'h07);
    repeat (24 * 6) @(posedge clk);
    @(negedge clk);
    check(pu_en == 8'h00 && pd_en == 8'h00, "R5 saturate at zero", pu_en, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule